// File: doc/BRIEF.md
# SPI Register Access Front End

This block is the serial control port of a radio-style control chip. A host drives an SPI mode-0 link (clock idles low, data captured on the rising edge, changed on the falling edge, most significant bit first). Every access opens with a one-byte header. Its top bit selects read (1) or write (0), the next bit selects burst, and the low six bits give an address. From that header the block routes the access to one of five targets: a bank of configuration registers, read-only status registers supplied from outside, command strobes, an eight-entry power table, or the transmit FIFO write port.

The SPI pins are brought into the system clock domain through two-stage synchronisers, so the system clock must run well above the serial clock. While the host clocks in a header or a write data byte, the block returns a status byte. That byte carries the chip state in bits 6:4 and a FIFO free-space nibble in bits 3:0, both taken from inputs, and bit 7 reads 0. A strobe raises a single-cycle pulse on one bit of a 14-bit vector that goes to an external sequencer. Two strobe positions, chosen by a parameter mask, are held back until chip select is released.

The FIFO write port is a valid/ready stream. A byte stays offered with `fifo_wvalid` high until `fifo_wready` is seen high on a clock edge. The serial link cannot be stalled. If another FIFO data byte completes while one is still waiting, the new byte replaces it. The host must therefore keep to the free count reported in the status byte.

Top module: `spi_reg_front`

## Requirements
- R1: The header is decoded as bit 7 = read (1) / write (0), bit 6 = burst, bits 5:0 = address; any byte received while no access is in progress is a header.
- R2: Addresses 0x00 to 0x2F hold configuration bytes that reset to 0x00, can be written and read back, and appear on `cfg_o`, with register n at bits 8n+7:8n.
- R3: MISO returns the status byte {0, chip_state, fifo_free} during every header byte and every write data byte, MSB first, and is 0 while chip select is high.
- R4: Without the burst bit, one data byte follows the header and the next byte is a new header. With the burst bit, the address advances by one after every byte until chip select rises. Write bytes addressed above 0x2F change nothing, and read bytes there return 0x00.
- R5: A header with read and burst set at address 0x30 to 0x3D returns status input byte (address - 0x30) from `stat_i` once, after which a new header is expected. A write with burst set in that range consumes data bytes and changes nothing.
- R6: A header at 0x30 to 0x3D with the burst bit clear is a strobe and carries no data. It pulses `strobe_o[address - 0x30]` high for exactly one clock, and another header may follow without releasing chip select.
- R7: Strobe positions set in DEFER_MASK (default 6 and 9, i.e. 0x36 and 0x39) do not pulse when the header arrives. They pulse once, one clock apart from nothing else, after chip select next rises.
- R8: Address 0x3E reaches the power table. Each data byte, read or written, uses the current index and then advances it by one, wrapping from 7 to 0. The index returns to 0 when chip select rises, and `pa_o` shows entry n at bits 8n+7:8n.
- R9: A write data byte at address 0x3F is offered on `fifo_wdata` with `fifo_wvalid` held high until accepted with `fifo_wready`. A read at 0x3F returns 0x00.
- R10: Raising chip select part-way through a byte discards that byte. Nothing is written, no FIFO byte is offered, and the next byte after chip select falls is decoded as a header.
- R11: After reset, `cfg_o` and `pa_o` are zero, `strobe_o` and `fifo_wvalid` are low and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, mode 0 |
| csn | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| chip_state | input | 3 | Chip state reported in the status byte |
| fifo_free | input | 4 | FIFO free-space nibble for the status byte |
| stat_i | input | 112 | Status register bytes, entry k at bits 8k+7:8k |
| cfg_o | output | 384 | Configuration register contents |
| pa_o | output | 64 | Power table contents |
| fifo_wdata | output | 8 | FIFO write byte |
| fifo_wvalid | output | 1 | FIFO write byte offered |
| fifo_wready | input | 1 | FIFO accepts the offered byte |
| strobe_o | output | 14 | One-cycle strobe pulses |

## Verification
The hardest behaviour to reach is the deferred strobe. It has to be shown that nothing pulses while chip select stays low, even after further headers have been issued, and that exactly one pulse follows its release. The stimulus issues a deferred strobe, then an immediate strobe and a status read inside the same selection, and compares pulse counts before and after the release. A second difficult case is the mid-byte abort. The bench clocks in a full write header and only four data bits, then releases chip select, and confirms through `cfg_o` and a fresh header that nothing was committed.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int AW = 6;
  localparam logic [AW-1:0] STAT_BASE = 6'h30;
  localparam logic [AW-1:0] PA_ADDR   = 6'h3E;
  localparam logic [AW-1:0] FIFO_ADDR = 6'h3F;

  typedef enum logic [1:0] {PH_HDR, PH_WR, PH_RD} phase_e;
  typedef enum logic [1:0] {TG_CFG, TG_STAT, TG_PA, TG_FIFO} target_e;
endpackage

// File: rtl/spi_fe_shifter.sv
module spi_fe_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] ld_byte_i,
  output logic              miso_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              byte_done_o,
  output logic              cs_act_o,
  output logic              cs_rise_o,
  output logic              cs_fall_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  logic [2:0] sclk_p, csn_p;
  logic [1:0] mosi_p;
  logic [CW-1:0] bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic sck_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      csn_p  <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk_i};
      csn_p  <= {csn_p[1:0], csn_i};
      mosi_p <= {mosi_p[0], mosi_i};
    end
  end

  assign cs_act_o  = ~csn_p[1];
  assign cs_rise_o = csn_p[1] & ~csn_p[2];
  assign cs_fall_o = ~csn_p[1] & csn_p[2];
  assign sck_rise  = cs_act_o & sclk_p[1] & ~sclk_p[2];
  assign sck_fall  = cs_act_o & ~sclk_p[1] & sclk_p[2];

  // Receive side: sample on rising SCLK, abort on deselect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt     <= '0;
      rx_sh       <= '0;
      rx_byte_o   <= '0;
      byte_done_o <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      if (!cs_act_o) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_p[1]};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          rx_byte_o   <= {rx_sh, mosi_p[1]};
          byte_done_o <= 1'b1;
          bit_cnt     <= '0;
        end
      end
    end
  end

  // Transmit side: shift on falling SCLK inside a byte only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
    end else if (ld_i) begin
      tx_sh <= ld_byte_i;
    end else if (sck_fall && bit_cnt != '0) begin
      tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso_o = cs_act_o & tx_sh[BYTE_W-1];

  AST_TX_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_p[1] && sclk_p[2] && !ld_i) |=> $stable(tx_sh)); // R3
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    csn_p[1] |-> !miso_o); // R3
endmodule

// File: rtl/spi_fe_decode.sv
module spi_fe_decode
  import spi_fe_pkg::*;
#(
  parameter int          CFG_DEPTH  = 48,
  parameter int          PA_DEPTH   = 8,
  parameter int          STAT_COUNT = 14,
  parameter logic [13:0] DEFER_MASK = 14'h0240
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         byte_done_i,
  input  logic [7:0]                   rx_byte_i,
  input  logic                         cs_act_i,
  input  logic                         cs_rise_i,
  input  logic                         cs_fall_i,
  input  logic                         fifo_ready_i,
  output phase_e                       phase_o,
  output target_e                      target_o,
  output logic [AW-1:0]                addr_o,
  output logic [$clog2(PA_DEPTH)-1:0]  pa_idx_o,
  output logic                         cfg_we_o,
  output logic [AW-1:0]                cfg_waddr_o,
  output logic                         pa_we_o,
  output logic [$clog2(PA_DEPTH)-1:0]  pa_widx_o,
  output logic [7:0]                   wdata_o,
  output logic                         fifo_valid_o,
  output logic [7:0]                   fifo_data_o,
  output logic [STAT_COUNT-1:0]        strobe_o,
  output logic                         ld_tx_o
);
  localparam int PW  = $clog2(PA_DEPTH);
  localparam int SIW = $clog2(STAT_COUNT);
  localparam logic [AW-1:0] CFG_END = AW'(CFG_DEPTH);
  localparam logic [STAT_COUNT-1:0] DMASK = DEFER_MASK[STAT_COUNT-1:0];

  logic                  burst_q;
  logic [STAT_COUNT-1:0] pend_q;
  logic                  hdr_rw, hdr_bu;
  logic [AW-1:0]         hdr_a, s_off;
  logic [SIW-1:0]        s_idx;

  assign hdr_rw = rx_byte_i[7];
  assign hdr_bu = rx_byte_i[6];
  assign hdr_a  = rx_byte_i[AW-1:0];
  assign s_off  = hdr_a - STAT_BASE;
  assign s_idx  = s_off[SIW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o      <= PH_HDR;
      target_o     <= TG_CFG;
      addr_o       <= '0;
      burst_q      <= 1'b0;
      pa_idx_o     <= '0;
      pend_q       <= '0;
      strobe_o     <= '0;
      cfg_we_o     <= 1'b0;
      cfg_waddr_o  <= '0;
      pa_we_o      <= 1'b0;
      pa_widx_o    <= '0;
      wdata_o      <= '0;
      fifo_valid_o <= 1'b0;
      fifo_data_o  <= '0;
      ld_tx_o      <= 1'b0;
    end else begin
      strobe_o <= '0;
      cfg_we_o <= 1'b0;
      pa_we_o  <= 1'b0;
      ld_tx_o  <= byte_done_i | cs_fall_i;
      if (fifo_valid_o && fifo_ready_i) fifo_valid_o <= 1'b0;

      if (cs_rise_i) begin
        phase_o  <= PH_HDR;
        pa_idx_o <= '0;
        strobe_o <= pend_q;
        pend_q   <= '0;
      end else if (byte_done_i) begin
        unique case (phase_o)
          PH_HDR: begin
            addr_o  <= hdr_a;
            burst_q <= hdr_bu;
            if (hdr_a < CFG_END) begin
              target_o <= TG_CFG;
              phase_o  <= hdr_rw ? PH_RD : PH_WR;
            end else if (hdr_a == PA_ADDR) begin
              target_o <= TG_PA;
              phase_o  <= hdr_rw ? PH_RD : PH_WR;
            end else if (hdr_a == FIFO_ADDR) begin
              target_o <= TG_FIFO;
              phase_o  <= hdr_rw ? PH_RD : PH_WR;
            end else if (hdr_bu) begin
              target_o <= TG_STAT;
              phase_o  <= hdr_rw ? PH_RD : PH_WR;
              burst_q  <= ~hdr_rw;
            end else if (DMASK[s_idx]) begin
              pend_q[s_idx] <= 1'b1;
            end else begin
              strobe_o <= STAT_COUNT'(1) << s_idx;
            end
          end
          PH_WR, PH_RD: begin
            if (phase_o == PH_WR) begin
              wdata_o     <= rx_byte_i;
              cfg_waddr_o <= addr_o;
              pa_widx_o   <= pa_idx_o;
              cfg_we_o    <= (target_o == TG_CFG) && (addr_o < CFG_END);
              pa_we_o     <= (target_o == TG_PA);
              if (target_o == TG_FIFO) begin
                fifo_valid_o <= 1'b1;
                fifo_data_o  <= rx_byte_i;
              end
            end
            if (target_o == TG_PA) pa_idx_o <= pa_idx_o + 1'b1;
            if (burst_q) addr_o <= addr_o + 1'b1;
            else         phase_o <= PH_HDR;
          end
          default: phase_o <= PH_HDR;
        endcase
      end
    end
  end

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_o || pa_we_o) |-> $past(cs_act_i, 2)); // R10
  AST_DEFER_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe_o & DMASK) != '0) |-> $past(cs_rise_i)); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o != '0) |=> ((strobe_o & $past(strobe_o)) == '0)); // R6
  AST_FIFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid_o && !fifo_ready_i) |=> (fifo_valid_o && $stable(fifo_data_o))); // R9
endmodule

// File: rtl/spi_fe_regs.sv
module spi_fe_regs
  import spi_fe_pkg::*;
#(
  parameter int CFG_DEPTH  = 48,
  parameter int PA_DEPTH   = 8,
  parameter int STAT_COUNT = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we_i,
  input  logic [AW-1:0]                cfg_waddr_i,
  input  logic                         pa_we_i,
  input  logic [$clog2(PA_DEPTH)-1:0]  pa_widx_i,
  input  logic [7:0]                   wdata_i,
  input  phase_e                       phase_i,
  input  target_e                      target_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [$clog2(PA_DEPTH)-1:0]  pa_idx_i,
  input  logic [STAT_COUNT*8-1:0]      stat_i,
  input  logic [2:0]                   chip_state_i,
  input  logic [3:0]                   fifo_free_i,
  output logic [CFG_DEPTH*8-1:0]       cfg_o,
  output logic [PA_DEPTH*8-1:0]        pa_o,
  output logic [7:0]                   tx_byte_o
);
  localparam int SIW = $clog2(STAT_COUNT);
  localparam int SPAD = 1 << SIW;
  localparam logic [AW-1:0] CFG_END  = AW'(CFG_DEPTH);
  localparam logic [AW-1:0] STAT_END = STAT_BASE + AW'(STAT_COUNT);

  logic [7:0] cfg_mem [CFG_DEPTH];
  logic [7:0] pa_mem  [PA_DEPTH];
  logic [7:0] stat_arr [SPAD];
  logic [AW-1:0] s_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_DEPTH; i++) cfg_mem[i] <= '0;
    end else if (cfg_we_i) begin
      cfg_mem[cfg_waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PA_DEPTH; i++) pa_mem[i] <= '0;
    end else if (pa_we_i) begin
      pa_mem[pa_widx_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < CFG_DEPTH; g++) begin : g_cfg_out
    assign cfg_o[g*8 +: 8] = cfg_mem[g];
  end
  for (genvar g = 0; g < PA_DEPTH; g++) begin : g_pa_out
    assign pa_o[g*8 +: 8] = pa_mem[g];
  end
  for (genvar g = 0; g < SPAD; g++) begin : g_stat
    if (g < STAT_COUNT) begin : g_used
      assign stat_arr[g] = stat_i[g*8 +: 8];
    end else begin : g_pad
      assign stat_arr[g] = '0;
    end
  end

  assign s_off = addr_i - STAT_BASE;

  always_comb begin
    tx_byte_o = {1'b0, chip_state_i, fifo_free_i};
    if (phase_i == PH_RD) begin
      unique case (target_i)
        TG_CFG:  tx_byte_o = (addr_i < CFG_END) ? cfg_mem[addr_i] : 8'h00;
        TG_PA:   tx_byte_o = pa_mem[pa_idx_i];
        TG_STAT: tx_byte_o = (addr_i >= STAT_BASE && addr_i < STAT_END)
                             ? stat_arr[s_off[SIW-1:0]] : 8'h00;
        default: tx_byte_o = 8'h00;
      endcase
    end
  end

  AST_CFG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |-> (cfg_waddr_i < CFG_END)); // R5
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we_i && pa_we_i)); // R4
endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_fe_pkg::*;
#(
  parameter int          CFG_DEPTH  = 48,
  parameter int          PA_DEPTH   = 8,
  parameter int          STAT_COUNT = 14,
  parameter logic [13:0] DEFER_MASK = 14'h0240
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk,
  input  logic                     csn,
  input  logic                     mosi,
  output logic                     miso,
  input  logic [2:0]               chip_state,
  input  logic [3:0]               fifo_free,
  input  logic [STAT_COUNT*8-1:0]  stat_i,
  output logic [CFG_DEPTH*8-1:0]   cfg_o,
  output logic [PA_DEPTH*8-1:0]    pa_o,
  output logic [7:0]               fifo_wdata,
  output logic                     fifo_wvalid,
  input  logic                     fifo_wready,
  output logic [STAT_COUNT-1:0]    strobe_o
);
  localparam int PW = $clog2(PA_DEPTH);

  logic          ld_tx, byte_done, cs_act, cs_rise, cs_fall;
  logic [7:0]    rx_byte, tx_byte, wdata;
  phase_e        phase;
  target_e       target;
  logic [AW-1:0] addr, cfg_waddr;
  logic [PW-1:0] pa_idx, pa_widx;
  logic          cfg_we, pa_we;

  spi_fe_shifter #(.BYTE_W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .ld_i(ld_tx), .ld_byte_i(tx_byte), .miso_o(miso), .rx_byte_o(rx_byte),
    .byte_done_o(byte_done), .cs_act_o(cs_act), .cs_rise_o(cs_rise),
    .cs_fall_o(cs_fall)
  );

  spi_fe_decode #(
    .CFG_DEPTH(CFG_DEPTH), .PA_DEPTH(PA_DEPTH), .STAT_COUNT(STAT_COUNT),
    .DEFER_MASK(DEFER_MASK)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .byte_done_i(byte_done), .rx_byte_i(rx_byte),
    .cs_act_i(cs_act), .cs_rise_i(cs_rise), .cs_fall_i(cs_fall),
    .fifo_ready_i(fifo_wready), .phase_o(phase), .target_o(target),
    .addr_o(addr), .pa_idx_o(pa_idx), .cfg_we_o(cfg_we),
    .cfg_waddr_o(cfg_waddr), .pa_we_o(pa_we), .pa_widx_o(pa_widx),
    .wdata_o(wdata), .fifo_valid_o(fifo_wvalid), .fifo_data_o(fifo_wdata),
    .strobe_o(strobe_o), .ld_tx_o(ld_tx)
  );

  spi_fe_regs #(
    .CFG_DEPTH(CFG_DEPTH), .PA_DEPTH(PA_DEPTH), .STAT_COUNT(STAT_COUNT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_waddr_i(cfg_waddr),
    .pa_we_i(pa_we), .pa_widx_i(pa_widx), .wdata_i(wdata), .phase_i(phase),
    .target_i(target), .addr_i(addr), .pa_idx_i(pa_idx), .stat_i(stat_i),
    .chip_state_i(chip_state), .fifo_free_i(fifo_free), .cfg_o(cfg_o),
    .pa_o(pa_o), .tx_byte_o(tx_byte)
  );
endmodule

// File: tb/tb_spi_reg_front.sv
module tb_spi_reg_front;
  localparam int NS = 14;
  logic clk = 0, rst_n = 0, sclk = 0, csn = 1, mosi = 0, fifo_wready = 1;
  logic miso, fifo_wvalid;
  logic [2:0] chip_state = 3'd0;
  logic [3:0] fifo_free = 4'd15;
  logic [NS*8-1:0] stat_i;
  logic [383:0] cfg_o;
  logic [63:0] pa_o;
  logic [7:0] fifo_wdata;
  logic [NS-1:0] strobe_o;

  spi_reg_front dut (.*);

  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit idle_chk = 0;
  // reference model state
  int m_phase = 0, m_tgt = 0, m_addr = 0, m_pa = 0;
  bit m_burst = 0;
  int exp_cnt[NS], act_cnt[NS];
  bit m_pend[NS];
  logic [NS-1:0] prev_strb = '0;
  logic [383:0] m_cfg = '0;
  logic [63:0] m_ptab = '0;
  logic [7:0] exp_q[$], act_q[$];

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_byte();
    return {1'b0, chip_state, fifo_free};
  endfunction

  function automatic logic [7:0] rd_val();
    case (m_tgt)
      0: return (m_addr < 48) ? m_cfg[m_addr*8 +: 8] : 8'h00;
      1: return stat_i[(m_addr-48)*8 +: 8];
      2: return m_ptab[m_pa*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic mdl_byte(input logic [7:0] tx, output logic [7:0] exp);
    int a;
    exp = (m_phase == 2) ? rd_val() : stat_byte();
    if (m_phase == 0) begin
      a = int'(tx[5:0]); m_addr = a; m_burst = tx[6];
      if (a < 48)       begin m_tgt = 0; m_phase = tx[7] ? 2 : 1; end
      else if (a == 62) begin m_tgt = 2; m_phase = tx[7] ? 2 : 1; end
      else if (a == 63) begin m_tgt = 3; m_phase = tx[7] ? 2 : 1; end
      else if (tx[6])   begin m_tgt = 1; m_phase = tx[7] ? 2 : 1; if (tx[7]) m_burst = 0; end
      else if (a - 48 == 6 || a - 48 == 9) m_pend[a-48] = 1;
      else exp_cnt[a-48]++;
    end else begin
      if (m_phase == 1) begin
        if (m_tgt == 0 && m_addr < 48) m_cfg[m_addr*8 +: 8] = tx;
        if (m_tgt == 2) m_ptab[m_pa*8 +: 8] = tx;
        if (m_tgt == 3) exp_q.push_back(tx);
      end
      if (m_tgt == 2) m_pa = (m_pa + 1) % 8;
      if (m_burst) m_addr = (m_addr + 1) % 64;
      else m_phase = 0;
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nb; b--) begin
      mosi = tx[b];
      repeat (6) @(posedge clk);
      @(negedge clk); rx[b] = miso; sclk = 1;
      repeat (6) @(posedge clk);
      @(negedge clk); sclk = 0;
    end
  endtask

  task automatic cs_begin();
    idle_chk = 0;
    @(negedge clk); csn = 0;
    repeat (8) @(posedge clk);
  endtask

  task automatic cs_end();
    repeat (4) @(posedge clk);
    @(negedge clk); csn = 1;
    m_phase = 0; m_pa = 0;
    for (int k = 0; k < NS; k++) if (m_pend[k]) begin exp_cnt[k]++; m_pend[k] = 0; end
    repeat (12) @(posedge clk);
    @(negedge clk); idle_chk = 1;
  endtask

  task automatic send(input logic [7:0] tx, input string req);
    logic [7:0] e, r;
    mdl_byte(tx, e);
    spi_bits(tx, 8, r);
    check(req, "miso byte", r, e);
  endtask

  task automatic chk_strobes(string req);
    for (int k = 0; k < NS; k++) check(req, "strobe count", act_cnt[k], exp_cnt[k]);
  endtask

  // per-clock comparison of the exposed state while idle
  always @(negedge clk) begin
    if (idle_chk) begin
      check("R2", "cfg_o idle", cfg_o[63:0], m_cfg[63:0]);
      if (cfg_o !== m_cfg) check("R2", "cfg_o upper", 64'(cfg_o >> 64), 64'(m_cfg >> 64));
      check("R8", "pa_o idle", pa_o, m_ptab);
      check("R3", "miso idle", 64'(miso), 64'(0));
    end
  end

  // strobe and FIFO monitors
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NS; k++) if (strobe_o[k]) begin
        act_cnt[k]++;
        if (prev_strb[k]) check("R6", "strobe width", 64'(2), 64'(1));
      end
      prev_strb = strobe_o;
      if (fifo_wvalid && fifo_wready) act_q.push_back(fifo_wdata);
    end
  end

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int k = 0; k < NS; k++) begin
      stat_i[k*8 +: 8] = 8'(8'h90 + k * 5);
      exp_cnt[k] = 0; act_cnt[k] = 0; m_pend[k] = 0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11", "cfg_o reset", 64'(cfg_o != '0), 64'(0));
    check("R11", "pa_o reset", pa_o, 64'(0));
    check("R11", "strobe reset", 64'(strobe_o), 64'(0));
    check("R11", "fifo_wvalid reset", 64'(fifo_wvalid), 64'(0));
    check("R11", "miso reset", 64'(miso), 64'(0));
    idle_chk = 1;

    // R1 R2 R3: single write then single read in one selection
    chip_state = 3'd5; fifo_free = 4'd9;
    cs_begin(); send(8'h05, "R1"); send(8'hA5, "R3"); send(8'h85, "R1"); send(8'h00, "R2"); cs_end();

    // R4 burst write across the top of the bank, then burst read
    chip_state = 3'd2; fifo_free = 4'd3;
    cs_begin(); send(8'h6C, "R4");
    for (int i = 0; i < 5; i++) send(8'(8'h31 + i * 17), "R4");
    cs_end();
    cs_begin(); send(8'hEC, "R4");
    for (int i = 0; i < 6; i++) send(8'h00, "R4");
    cs_end();
    cs_begin(); send(8'h2A, "R4"); send(8'h5C, "R4"); send(8'h2B, "R4"); send(8'h6D, "R4"); cs_end();

    // R5 status reads, single byte each, back to back; burst write ignored
    cs_begin(); send(8'hF3, "R5"); send(8'h00, "R5"); send(8'hFD, "R5"); send(8'h00, "R5"); send(8'hF0, "R5"); send(8'h00, "R5"); cs_end();
    cs_begin(); send(8'h70, "R5"); send(8'hEE, "R5"); send(8'h77, "R5"); cs_end();
    chk_strobes("R5");

    // R6 immediate strobes with headers following, R7 deferred strobes
    cs_begin(); send(8'h31, "R6");
    repeat (10) @(posedge clk); @(negedge clk);
    check("R6", "immediate strobe count", 64'(act_cnt[1]), 64'(exp_cnt[1]));
    send(8'h36, "R7"); send(8'h3D, "R6"); send(8'hF2, "R6"); send(8'h00, "R6"); send(8'h39, "R7");
    repeat (10) @(posedge clk); @(negedge clk);
    check("R7", "deferred held 6", 64'(act_cnt[6]), 64'(0));
    check("R7", "deferred held 9", 64'(act_cnt[9]), 64'(0));
    cs_end();
    check("R7", "deferred after rise 6", 64'(act_cnt[6]), 64'(1));
    check("R7", "deferred after rise 9", 64'(act_cnt[9]), 64'(1));
    chk_strobes("R6");

    // R8 power table: burst with wrap, single accesses, read back
    cs_begin(); send(8'h7E, "R8");
    for (int i = 0; i < 9; i++) send(8'(8'h11 * (i + 1)), "R8");
    cs_end();
    cs_begin(); send(8'h3E, "R8"); send(8'hC3, "R8"); send(8'h3E, "R8"); send(8'h3C, "R8"); cs_end();
    cs_begin(); send(8'hFE, "R8");
    for (int i = 0; i < 8; i++) send(8'h00, "R8");
    cs_end();

    // R9 FIFO burst, read, and back-pressure
    fifo_wready = 1;
    cs_begin(); send(8'h7F, "R9"); send(8'hDE, "R9"); send(8'hAD, "R9"); send(8'hBE, "R9"); cs_end();
    cs_begin(); send(8'hBF, "R9"); send(8'h00, "R9"); cs_end();
    fifo_wready = 0;
    cs_begin(); send(8'h3F, "R9"); send(8'hC7, "R9"); cs_end();
    check("R9", "valid held", 64'(fifo_wvalid), 64'(1));
    check("R9", "data held", 64'(fifo_wdata), 64'(8'hC7));
    @(negedge clk); fifo_wready = 1;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R9", "valid dropped", 64'(fifo_wvalid), 64'(0));
    check("R9", "fifo count", 64'(act_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
      check("R9", "fifo byte", 64'(act_q[i]), 64'(exp_q[i]));

    // R10 abort mid-byte, then a fresh header
    cs_begin(); send(8'h07, "R10");
    spi_bits(8'hFF, 4, r);
    cs_end();
    check("R10", "no partial commit", 64'(cfg_o[7*8 +: 8]), 64'(0));
    cs_begin(); send(8'h87, "R10"); send(8'h00, "R10"); cs_end();
    check("R10", "no fifo offer", 64'(act_q.size()), 64'(exp_q.size()));
    chk_strobes("R6");

    idle_chk = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule